// File: doc/BRIEF.md
# Status Overflow Bit Unit

This block owns the signed-overflow bit of an 8-bit processor status byte in a CPU whose accumulator can run 8 or 16 bits wide. On every cycle where the update strobe is high, an operation-class code decides whether the bit is recomputed, forced, loaded or left alone. The arithmetic classes judge signed overflow at the width chosen by a mode input. The mask classes can only move the bit in one direction. The load classes copy it from a memory word or from a status byte pulled off the stack.

The unit sits beside the ALU and the flag logic. The decoder supplies the class code, the mode bit and the operands. The unit returns the registered bit. The ALU result and the other flags are computed elsewhere.

Top module: `ovf_flag_unit`

## Requirements
- R1: While rst_ni is low, ovf_o is 0. It stays 0 after release until an update changes it.
- R2: ovf_o keeps its value across a clock edge when upd_i is 0. It also keeps its value when op_i is 0 (hold) or any code from 9 to 15.
- R3: With op_i = 1 (add) and wide_i = 0, ovf_o becomes 1 after the edge exactly when the signed value of opa_i[7:0] + opb_i[7:0] + cin_i lies outside -128..127. Bits 15:8 of both operands have no effect.
- R4: With op_i = 1 and wide_i = 1, ovf_o becomes 1 exactly when the signed 16-bit sum opa_i + opb_i + cin_i lies outside -32768..32767.
- R5: With op_i = 2 (subtract), ovf_o becomes 1 exactly when the signed value A - B - (1 - cin_i) lies outside the range of the active width (8 bits when wide_i = 0, 16 bits when wide_i = 1).
- R6: op_i = 3 (clear) makes ovf_o 0.
- R7: op_i = 4 (mask-set) makes ovf_o 1 when mask_i[6] is 1. Otherwise ovf_o is unchanged.
- R8: op_i = 5 (mask-reset) makes ovf_o 0 when mask_i[6] is 1. Otherwise ovf_o is unchanged.
- R9: op_i = 6 (bit-test) loads ovf_o from mem_i[6] when wide_i = 0, and from mem_i[14] when wide_i = 1.
- R10: op_i = 7 (pull-status) and op_i = 8 (interrupt return) both load ovf_o from pulled_i[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Update strobe |
| op_i | input | 4 | Operation class code |
| wide_i | input | 1 | 1 selects 16-bit accumulator mode |
| opa_i | input | 16 | Adder operand A |
| opb_i | input | 16 | Adder operand B |
| cin_i | input | 1 | Carry in (1 means no borrow on subtract) |
| mem_i | input | 16 | Memory operand for bit-test |
| pulled_i | input | 8 | Status byte pulled from the stack |
| mask_i | input | 8 | Immediate status mask |
| ovf_o | output | 1 | Registered overflow bit |

## Verification
The hardest cases to reach are subtraction results that land exactly on a range edge, where the carry-in alone decides overflow. Narrow-mode arithmetic with garbage in the upper operand bytes is equally hard. Directed vectors place operands at the edge of each width with both carry values. Random vectors fill the unused upper byte with noise and are scored against a full-precision signed reference. Before each hold and mask case, the bit is preset to the value the case could disturb, using a pull-status load.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int OP_W   = 4;
  localparam int V_BIT  = 6;
  localparam int SR_W   = 8;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CLR  = 4'd3,
    OP_SETM = 4'd4,
    OP_RSTM = 4'd5,
    OP_TEST = 4'd6,
    OP_PULL = 4'd7,
    OP_RETI = 4'd8
  } ovf_op_e;
endpackage

// File: rtl/ovf_arith.sv
module ovf_arith #(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          sub_i,
  input  logic          wide_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic          ovf_o
);
  localparam int N_WID = 2;
  logic [N_WID-1:0] ovf_w;

  for (genvar g = 0; g < N_WID; g++) begin : g_wid
    localparam int W = (g == 0) ? NW : DW;
    logic [W-1:0] a_s, b_s, sum_s;
    assign a_s   = a_i[W-1:0];
    // subtract: A + ~B + C
    assign b_s   = sub_i ? ~b_i[W-1:0] : b_i[W-1:0];
    assign sum_s = a_s + b_s + W'(cin_i);
    assign ovf_w[g] = (a_s[W-1] == b_s[W-1]) && (sum_s[W-1] != a_s[W-1]);
  end

  assign ovf_o = wide_i ? ovf_w[1] : ovf_w[0];
endmodule

// File: rtl/ovf_next.sv
module ovf_next
  import ovf_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  ovf_op_e         op_i,
  input  logic            wide_i,
  input  logic            cur_i,
  input  logic            arith_i,
  input  logic [DW-1:0]   mem_i,
  input  logic [SR_W-1:0] pulled_i,
  input  logic [SR_W-1:0] mask_i,
  output logic            nxt_o
);
  logic test_bit;
  // second-highest bit of the active width
  assign test_bit = wide_i ? mem_i[DW-2] : mem_i[NW-2];

  always_comb begin
    nxt_o = cur_i;
    unique case (op_i)
      OP_ADD, OP_SUB:  nxt_o = arith_i;
      OP_CLR:          nxt_o = 1'b0;
      OP_SETM:         nxt_o = cur_i | mask_i[V_BIT];
      OP_RSTM:         nxt_o = cur_i & ~mask_i[V_BIT];
      OP_TEST:         nxt_o = test_bit;
      OP_PULL, OP_RETI: nxt_o = pulled_i[V_BIT];
      default:         nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/ovf_reg.sv
module ovf_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ovf_flag_unit.sv
module ovf_flag_unit
  import ovf_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [3:0]    op_i,
  input  logic          wide_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          cin_i,
  input  logic [DW-1:0] mem_i,
  input  logic [7:0]    pulled_i,
  input  logic [7:0]    mask_i,
  output logic          ovf_o
);
  ovf_op_e op;
  logic    arith_ovf, nxt;

  assign op = ovf_op_e'(op_i);

  ovf_arith #(.DW(DW), .NW(NW)) u_arith (
    .sub_i (op == OP_SUB),
    .wide_i(wide_i),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .cin_i (cin_i),
    .ovf_o (arith_ovf)
  );

  ovf_next #(.DW(DW), .NW(NW)) u_next (
    .op_i    (op),
    .wide_i  (wide_i),
    .cur_i   (ovf_o),
    .arith_i (arith_ovf),
    .mem_i   (mem_i),
    .pulled_i(pulled_i),
    .mask_i  (mask_i),
    .nxt_o   (nxt)
  );

  ovf_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (upd_i),
    .d_i   (nxt),
    .q_o   (ovf_o)
  );

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i || op_i == 4'd0 || op_i > 4'd8) |=> $stable(ovf_o));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 4'd1 && !wide_i && opa_i[NW-1] != opb_i[NW-1]) |=> !ovf_o);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 4'd3) |=> !ovf_o);
  p_setm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 4'd4 && mask_i[6]) |=> ovf_o);
  p_rstm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 4'd5 && mask_i[6]) |=> !ovf_o);
  p_test_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == 4'd6 && wide_i) |=> ovf_o == $past(mem_i[DW-2]));
  p_pull_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (op_i == 4'd7 || op_i == 4'd8)) |=> ovf_o == $past(pulled_i[6]));
endmodule

// File: tb/ovf_flag_unit_bench.sv
`timescale 1ns/1ps
module ovf_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0, mem = '0;
  logic        cin = 1'b0;
  logic [7:0]  pulled = '0, mask = '0;
  logic        ovf;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ovf_flag_unit u_ovf_flag_unit (
    .clk_i(clk), .rst_ni(rst_ni), .upd_i(upd), .op_i(op), .wide_i(wide),
    .opa_i(opa), .opb_i(opb), .cin_i(cin), .mem_i(mem),
    .pulled_i(pulled), .mask_i(mask), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ovf_o=%b expected %b", req, act, exp);
    end
  endtask

  // drive one cycle, sample after the edge
  task automatic apply(logic u, logic [3:0] o);
    @(negedge clk);
    upd = u; op = o;
    @(posedge clk); #1;
    upd = 1'b0;
  endtask

  task automatic preset(logic v);
    pulled = v ? 8'h40 : 8'hBF;
    apply(1'b1, 4'd7);
  endtask

  function automatic logic ref_ovf(logic sub, logic w, logic [15:0] a, logic [15:0] b, logic c);
    int sa, sb, r, lim;
    if (w) begin sa = int'($signed(a)); sb = int'($signed(b)); lim = 32767; end
    else begin sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0])); lim = 127; end
    r = sub ? (sa - sb - (c ? 0 : 1)) : (sa + sb + int'(c));
    return (r > lim) || (r < -lim - 1);
  endfunction

  task automatic arith(string req, logic sub, logic w, logic [15:0] a, logic [15:0] b, logic c);
    wide = w; opa = a; opb = b; cin = c;
    apply(1'b1, sub ? 4'd2 : 4'd1);
    check(req, ovf, ref_ovf(sub, w, a, b, c));
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", ovf, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1 check("R1 after release", ovf, 1'b0);
  endtask

  task automatic t_hold;
    preset(1'b1);
    apply(1'b0, 4'd3);  check("R2 strobe low", ovf, 1'b1);
    apply(1'b1, 4'd0);  check("R2 hold code", ovf, 1'b1);
    for (int c = 9; c < 16; c++) begin
      apply(1'b1, 4'(c)); check("R2 unused code", ovf, 1'b1);
    end
    preset(1'b0);
    mask = 8'h40;
    apply(1'b0, 4'd4);  check("R2 strobe low mask-set", ovf, 1'b0);
  endtask

  task automatic t_add_narrow;
    arith("R3 127+1", 0, 0, 16'h007F, 16'h0001, 0);
    arith("R3 126+0+c", 0, 0, 16'h007E, 16'h0000, 1);
    arith("R3 127+0+c", 0, 0, 16'h007F, 16'h0000, 1);
    arith("R3 -128+-1", 0, 0, 16'h0080, 16'h00FF, 0);
    arith("R3 -128+-1+c", 0, 0, 16'h0080, 16'h00FF, 1);
    arith("R3 upper noise", 0, 0, 16'h7F01, 16'h7F01, 0);
    for (int i = 0; i < 300; i++)
      arith("R3 random", 0, 0, 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  task automatic t_add_wide;
    arith("R4 32767+1", 0, 1, 16'h7FFF, 16'h0001, 0);
    arith("R4 32767+0+c", 0, 1, 16'h7FFF, 16'h0000, 1);
    arith("R4 0x7F+1 no ovf", 0, 1, 16'h007F, 16'h0001, 0);
    arith("R4 -32768+-1", 0, 1, 16'h8000, 16'hFFFF, 0);
    for (int i = 0; i < 300; i++)
      arith("R4 random", 0, 1, 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  task automatic t_sub;
    arith("R5 -128-0 borrow", 1, 0, 16'h0080, 16'h0000, 0);
    arith("R5 -128-0 no borrow", 1, 0, 16'h0080, 16'h0000, 1);
    arith("R5 127-(-1)", 1, 0, 16'h007F, 16'h00FF, 1);
    arith("R5 0-(-128)", 1, 0, 16'h0000, 16'h0080, 1);
    arith("R5 wide -32768-1", 1, 1, 16'h8000, 16'h0001, 1);
    arith("R5 wide 0x80-0 borrow", 1, 1, 16'h0080, 16'h0000, 0);
    for (int i = 0; i < 400; i++)
      arith("R5 random", 1, 1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  task automatic t_clear;
    preset(1'b1);
    apply(1'b1, 4'd3); check("R6 clear", ovf, 1'b0);
  endtask

  task automatic t_masks;
    preset(1'b0);
    mask = 8'hBF; apply(1'b1, 4'd4); check("R7 mask bit clear", ovf, 1'b0);
    mask = 8'h40; apply(1'b1, 4'd4); check("R7 mask set", ovf, 1'b1);
    mask = 8'h40; apply(1'b1, 4'd4); check("R7 mask set keeps", ovf, 1'b1);
    mask = 8'hBF; apply(1'b1, 4'd5); check("R8 mask bit clear", ovf, 1'b1);
    mask = 8'h40; apply(1'b1, 4'd5); check("R8 mask reset", ovf, 1'b0);
    mask = 8'h40; apply(1'b1, 4'd5); check("R8 mask reset keeps", ovf, 1'b0);
  endtask

  task automatic t_test;
    preset(1'b0);
    wide = 0; mem = 16'h0040; apply(1'b1, 4'd6); check("R9 narrow bit6", ovf, 1'b1);
    wide = 0; mem = 16'hFFBF; apply(1'b1, 4'd6); check("R9 narrow ignores bit14", ovf, 1'b0);
    wide = 1; mem = 16'h4000; apply(1'b1, 4'd6); check("R9 wide bit14", ovf, 1'b1);
    wide = 1; mem = 16'hBFFF; apply(1'b1, 4'd6); check("R9 wide ignores bit6", ovf, 1'b0);
  endtask

  task automatic t_pull;
    pulled = 8'h40; apply(1'b1, 4'd7); check("R10 pull set", ovf, 1'b1);
    pulled = 8'hBF; apply(1'b1, 4'd7); check("R10 pull clear", ovf, 1'b0);
    pulled = 8'h40; apply(1'b1, 4'd8); check("R10 return set", ovf, 1'b1);
    pulled = 8'hBF; apply(1'b1, 4'd8); check("R10 return clear", ovf, 1'b0);
  endtask

  initial begin
    t_reset;
    t_hold;
    t_add_narrow;
    t_add_wide;
    t_sub;
    t_clear;
    t_masks;
    t_test;
    t_pull;
    preset(1'b1);
    t_reset;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule